// File: doc/BRIEF.md
# Pipelined AES-128 Block Encryptor

This block encrypts 128-bit blocks under a 128-bit key by the AES-128 algorithm. All ten rounds are unrolled. Each round is a single slice of combinational logic, and one register stage sits between rounds. A new plaintext block can therefore enter on every clock edge. Its ciphertext appears eleven cycles later, and a completed block leaves on every cycle once the pipe is full. Each round performs sixteen parallel S-box substitutions, a fixed byte permutation for the row shift, four parallel column mixers (skipped in the tenth round) and an XOR with that round's key.

The round keys are expanded on the fly inside the pipe. Each stage carries its own block, its own round key and a valid bit, so consecutive blocks can use different keys with no stall. The key is held in a key register that is written while `key_load` is high. A block accepted in the same cycle as a key load is encrypted under the new key.

Top module: `aes128_pipe_enc`

## Requirements
- R1: After reset, `out_valid` stays low until the first accepted block emerges. `out_valid` is never high in the first 11 cycles after reset.
- R2: A block accepted on a clock edge (with `in_valid` high) appears on `cipher_out` with `out_valid` high exactly 11 clock edges later. The value on `cipher_out` is its AES-128 ciphertext.
- R3: Blocks accepted on consecutive edges leave on consecutive edges, in order, with no gap.
- R4: When `key_load` and `in_valid` are both high on the same edge, that block is encrypted with the `key_in` presented on that edge. The key register then holds that key for later blocks.
- R5: While `key_load` is low, `key_in` has no effect. Blocks use the most recently loaded key.
- R6: An edge with `in_valid` low produces no output. Exactly 11 edges later, `out_valid` is low.
- R7: Byte order follows the standard column-major convention. Bits [127:120] of `plain_in`, `key_in` and `cipher_out` are byte 0, which is row 0 of column 0. Bits [95:88] are byte 4, which is row 0 of column 1. For example, key 000102030405060708090a0b0c0d0e0f with plaintext 00112233445566778899aabbccddeeff gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R8: A synchronous reset (`rst` high on an edge) discards every block in flight. It also clears the key register to all zeros, so a later block that is accepted with no key load is encrypted under the zero key.
- R9: A key load with `in_valid` low updates the key register and produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Accept `plain_in` on this edge |
| key_load | input | 1 | Write `key_in` into the key register on this edge |
| key_in | input | 128 | Cipher key, byte 0 in bits [127:120] |
| plain_in | input | 128 | Plaintext block, byte 0 in bits [127:120] |
| cipher_out | output | 128 | Ciphertext of the block leaving stage 11 |
| out_valid | output | 1 | `cipher_out` holds a real result |

## Verification
Two functions can fall on the same edge: a key-register write and the acceptance of a block that must already use that key. The bench provokes this in two ways. It loads a fresh key together with a block, and it does so on several back-to-back edges, each with a different key. It also loads a key on an idle edge and then sends blocks with no load, while `key_in` carries garbage. Every output is compared, in the cycle it is due, against an independent software model that tracks which key each block should have seen. A second overlap is a reset arriving while blocks are in flight. The bench judges that case by the absence of any output and by the zero key that later blocks use.

// File: rtl/aes_pkg.sv
package aes_pkg;

    localparam int BLK_W      = 128;
    localparam int NUM_ROUNDS = 10;
    localparam int N_BYTES    = BLK_W / 8;
    localparam int N_COLS     = 4;
    localparam int STAGES     = NUM_ROUNDS + 1;

    typedef logic [7:0]       byte_t;
    typedef logic [31:0]      word_t;
    typedef logic [BLK_W-1:0] blk_t;

    // One pipeline slot: qualifier, cipher state and the key applied in it
    typedef struct packed {
        logic vld;
        blk_t st;
        blk_t rk;
    } stage_t;

    function automatic byte_t xtime(input byte_t b);
        return {b[6:0], 1'b0} ^ (b[7] ? 8'h1B : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc = 8'h00;
        byte_t aa  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ aa;
            aa = xtime(aa);
        end
        return acc;
    endfunction

    // Multiplicative inverse as b^254 (maps zero to zero)
    function automatic byte_t gf_inv(input byte_t b);
        byte_t p2   = gf_mul(b, b);
        byte_t p4   = gf_mul(p2, p2);
        byte_t p8   = gf_mul(p4, p4);
        byte_t p16  = gf_mul(p8, p8);
        byte_t p32  = gf_mul(p16, p16);
        byte_t p64  = gf_mul(p32, p32);
        byte_t p128 = gf_mul(p64, p64);
        return gf_mul(gf_mul(gf_mul(p2, p4), gf_mul(p8, p16)),
                      gf_mul(gf_mul(p32, p64), p128));
    endfunction

    function automatic byte_t rotl1(input byte_t v);
        return {v[6:0], v[7]};
    endfunction

    function automatic byte_t sbox(input byte_t b);
        byte_t iv = gf_inv(b);
        byte_t r1 = rotl1(iv);
        byte_t r2 = rotl1(r1);
        byte_t r3 = rotl1(r2);
        byte_t r4 = rotl1(r3);
        return iv ^ r1 ^ r2 ^ r3 ^ r4 ^ 8'h63;
    endfunction

    function automatic word_t sub_word(input word_t w);
        return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
    endfunction

    // Round constant for round r (1-based)
    function automatic byte_t rcon_of(input int r);
        byte_t v = 8'h01;
        for (int i = 1; i < r; i++) v = xtime(v);
        return v;
    endfunction

endpackage

// File: rtl/aes_subshift.sv
module aes_subshift
    import aes_pkg::*;
(
    input  blk_t din,
    output blk_t dout
);
    // Byte k sits at row k%4, column k/4; row r is rotated left by r columns
    for (genvar gi = 0; gi < N_BYTES; gi++) begin : g_byte
        localparam int ROW = gi % N_COLS;
        localparam int COL = gi / N_COLS;
        localparam int SRC = ROW + N_COLS * ((COL + ROW) % N_COLS);
        assign dout[BLK_W-1-8*gi -: 8] = sbox(din[BLK_W-1-8*SRC -: 8]);
    end
endmodule

// File: rtl/aes_mix_column.sv
module aes_mix_column
    import aes_pkg::*;
(
    input  word_t col_in,
    output word_t col_out
);
    byte_t a0, a1, a2, a3;
    byte_t d0, d1, d2, d3;

    assign {a0, a1, a2, a3} = col_in;
    assign d0 = xtime(a0);
    assign d1 = xtime(a1);
    assign d2 = xtime(a2);
    assign d3 = xtime(a3);

    // Triple of x is double of x xor x
    assign col_out[31:24] = d0 ^ (d1 ^ a1) ^ a2 ^ a3;
    assign col_out[23:16] = a0 ^ d1 ^ (d2 ^ a2) ^ a3;
    assign col_out[15:8]  = a0 ^ a1 ^ d2 ^ (d3 ^ a3);
    assign col_out[7:0]   = (d0 ^ a0) ^ a1 ^ a2 ^ d3;
endmodule

// File: rtl/aes_mix_state.sv
module aes_mix_state
    import aes_pkg::*;
#(
    parameter bit BYPASS = 1'b0
) (
    input  blk_t din,
    output blk_t dout
);
    if (BYPASS) begin : g_pass
        assign dout = din;
    end else begin : g_mix
        for (genvar gc = 0; gc < N_COLS; gc++) begin : g_col
            aes_mix_column u_col (
                .col_in (din [BLK_W-1-32*gc -: 32]),
                .col_out(dout[BLK_W-1-32*gc -: 32])
            );
        end
    end
endmodule

// File: rtl/aes_key_step.sv
module aes_key_step
    import aes_pkg::*;
#(
    parameter int RIDX = 1
) (
    input  blk_t key_prev,
    output blk_t key_next
);
    localparam byte_t RC = rcon_of(RIDX);

    word_t w0, w1, w2, w3, mix, n0, n1, n2, n3;

    assign {w0, w1, w2, w3} = key_prev;
    assign mix = sub_word({w3[23:0], w3[31:24]}) ^ {RC, 24'h000000};
    assign n0  = w0 ^ mix;
    assign n1  = w1 ^ n0;
    assign n2  = w2 ^ n1;
    assign n3  = w3 ^ n2;
    assign key_next = {n0, n1, n2, n3};
endmodule

// File: rtl/aes_round.sv
module aes_round
    import aes_pkg::*;
#(
    parameter int RIDX  = 1,
    parameter bit FINAL = 1'b0
) (
    input  stage_t prev,
    output stage_t nxt
);
    blk_t sub_sh, mixed, rkey;

    aes_subshift u_ss (
        .din (prev.st),
        .dout(sub_sh)
    );

    aes_mix_state #(.BYPASS(FINAL)) u_mix (
        .din (sub_sh),
        .dout(mixed)
    );

    aes_key_step #(.RIDX(RIDX)) u_key (
        .key_prev(prev.rk),
        .key_next(rkey)
    );

    assign nxt.vld = prev.vld;
    assign nxt.st  = mixed ^ rkey;
    assign nxt.rk  = rkey;
endmodule

// File: rtl/aes128_pipe_enc.sv
module aes128_pipe_enc
    import aes_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic             key_load,
    input  logic [BLK_W-1:0] key_in,
    input  logic [BLK_W-1:0] plain_in,
    output logic [BLK_W-1:0] cipher_out,
    output logic             out_valid
);
    blk_t   key_q;
    blk_t   eff_key;
    stage_t pipe    [STAGES];
    stage_t rnd_out [STAGES];

    // A load in the same cycle as a block takes effect for that block
    assign eff_key = key_load ? key_in : key_q;

    always_ff @(posedge clk) begin
        if (rst)           key_q <= '0;
        else if (key_load) key_q <= key_in;
    end

    assign rnd_out[0].vld = in_valid;
    assign rnd_out[0].st  = plain_in ^ eff_key;
    assign rnd_out[0].rk  = eff_key;

    for (genvar gi = 1; gi < STAGES; gi++) begin : g_round
        aes_round #(
            .RIDX (gi),
            .FINAL(gi == NUM_ROUNDS)
        ) u_round (
            .prev(pipe[gi-1]),
            .nxt (rnd_out[gi])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i].vld <= 1'b0;
        end else begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= rnd_out[i];
        end
    end

    assign cipher_out = pipe[STAGES-1].st;
    assign out_valid  = pipe[STAGES-1].vld;
endmodule

// File: rtl/aes128_pipe_chk.sv
module aes128_pipe_chk
    import aes_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       key_load,
    input blk_t       key_in,
    input blk_t       key_q,
    input logic       out_valid
);
    logic [3:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                   since_rst <= '0;
        else if (since_rst != 4'hF) since_rst <= since_rst + 4'd1;
    end

    // R1
    no_early_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst < 4'd11) |-> !out_valid);

    // R2 R3 R6
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 4'd11) |-> (out_valid == $past(in_valid, 11)));

    // R4 R9
    key_write_chk: assert property (@(posedge clk) disable iff (rst)
        key_load |=> (key_q == $past(key_in)));

    // R5
    key_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !key_load |=> $stable(key_q));
endmodule

bind aes128_pipe_enc aes128_pipe_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .key_load (key_load),
    .key_in   (key_in),
    .key_q    (key_q),
    .out_valid(out_valid)
);

// File: tb/tb_aes128_pipe_enc.sv
`timescale 1ns/1ps
module tb_aes128_pipe_enc;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         key_load = 1'b0;
    logic [127:0] key_in = '0;
    logic [127:0] plain_in = '0;
    logic [127:0] cipher_out;
    logic         out_valid;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    logic [127:0] exp_q [$];
    int           due_q [$];
    string        tag_q [$];
    logic [127:0] model_key = '0;
    logic [7:0]   sb [256];

    aes128_pipe_enc dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .key_load(key_load),
        .key_in(key_in), .plain_in(plain_in),
        .cipher_out(cipher_out), .out_valid(out_valid)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // ---------------- reference model ----------------
    function automatic logic [7:0] rl(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

    function automatic logic [7:0] dbl(input logic [7:0] v);
        return v[7] ? ((v << 1) ^ 8'h1B) : (v << 1);
    endfunction

    task automatic build_sbox();
        logic [7:0] p = 8'h01;
        logic [7:0] q = 8'h01;
        do begin
            p = p ^ dbl(p);
            q = q ^ (q << 1);
            q = q ^ (q << 2);
            q = q ^ (q << 4);
            if (q[7]) q = q ^ 8'h09;
            sb[p] = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4) ^ 8'h63;
        end while (p != 8'h01);
        sb[0] = 8'h63;
    endtask

    function automatic logic [127:0] ref_enc(input logic [127:0] k, input logic [127:0] p);
        logic [31:0]  w [44];
        logic [7:0]   s [16];
        logic [7:0]   t [16];
        logic [7:0]   rc = 8'h01;
        logic [31:0]  tmp;
        logic [127:0] res;
        for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            tmp = w[i-1];
            if (i % 4 == 0) begin
                tmp = {sb[tmp[23:16]], sb[tmp[15:8]], sb[tmp[7:0]], sb[tmp[31:24]]} ^ {rc, 24'h0};
                rc = dbl(rc);
            end
            w[i] = w[i-4] ^ tmp;
        end
        for (int i = 0; i < 16; i++) s[i] = p[127-8*i -: 8] ^ w[i/4][31-8*(i%4) -: 8];
        for (int rnd = 1; rnd <= 10; rnd++) begin
            for (int i = 0; i < 16; i++) t[i] = sb[s[i]];
            for (int c = 0; c < 4; c++)
                for (int rw = 0; rw < 4; rw++)
                    s[rw + 4*c] = t[rw + 4*((c + rw) % 4)];
            if (rnd < 10) begin
                for (int c = 0; c < 4; c++) begin
                    logic [7:0] a0, a1, a2, a3;
                    a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
                    s[4*c]   = dbl(a0) ^ dbl(a1) ^ a1 ^ a2 ^ a3;
                    s[4*c+1] = a0 ^ dbl(a1) ^ dbl(a2) ^ a2 ^ a3;
                    s[4*c+2] = a0 ^ a1 ^ dbl(a2) ^ dbl(a3) ^ a3;
                    s[4*c+3] = dbl(a0) ^ a0 ^ a1 ^ a2 ^ dbl(a3);
                end
            end
            for (int i = 0; i < 16; i++) s[i] = s[i] ^ w[4*rnd + i/4][31-8*(i%4) -: 8];
        end
        for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
        return res;
    endfunction

    // ---------------- driver ----------------
    task automatic drive(input bit vld, input bit kld, input logic [127:0] k,
                         input logic [127:0] p, input string tag,
                         input bit use_exp = 0, input logic [127:0] exp_val = '0);
        @(negedge clk);
        in_valid = vld;
        key_load = kld;
        key_in   = k;
        plain_in = p;
        if (kld) model_key = k;
        if (vld) begin
            exp_q.push_back(use_exp ? exp_val : ref_enc(model_key, p));
            due_q.push_back(cyc + 11);
            tag_q.push_back(tag);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, {4{32'hBAD0_F00D}}, {4{32'h5A5A_A5A5}}, "R6");
    endtask

    // ---------------- monitor / scoreboard ----------------
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (out_valid) begin
                if (due_q.size() == 0 || due_q[0] != cyc) begin
                    checks++; errors++;
                    $display("FAIL R6 unexpected out_valid at cycle %0d: actual 1 expected 0", cyc);
                end else begin
                    checks++;
                    if (cipher_out !== exp_q[0]) begin
                        errors++;
                        $display("FAIL %s R2 cycle %0d: actual %h expected %h",
                                 tag_q[0], cyc, cipher_out, exp_q[0]);
                    end
                    void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
                end
            end else if (due_q.size() != 0 && due_q[0] == cyc) begin
                checks++; errors++;
                $display("FAIL %s R3 missing output at cycle %0d: actual out_valid 0 expected 1",
                         tag_q[0], cyc);
                void'(exp_q.pop_front()); void'(due_q.pop_front()); void'(tag_q.pop_front());
            end
        end
    end

    // ---------------- watchdog ----------------
    initial begin
        #(8.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [127:0] k, p;
        build_sbox();
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset state: actual out_valid %b expected 0", out_valid);
        end
        @(negedge clk);
        rst = 1'b0;

        // R1: idle after reset, monitor flags any valid
        idle(13);

        // R7 R4: standard example vectors, key loaded together with block
        drive(1, 1, 128'h000102030405060708090a0b0c0d0e0f,
              128'h00112233445566778899aabbccddeeff, "R7", 1,
              128'h69c4e0d86a7b0430d8cdb78070b4c55a);
        drive(1, 1, 128'h2b7e151628aed2a6abf7158809cf4f3c,
              128'h3243f6a8885a308d313198a2e0370734, "R7", 1,
              128'h3925841d02dc09fbdc118597196a0b32);
        idle(14);

        // R3 R5: back-to-back stream, key reloaded every fifth block, garbage key otherwise
        for (int i = 0; i < 24; i++) begin
            p = {4{32'h1357_9BDF ^ (32'h0101_0101 * i)}} ^ {i[15:0], 112'h0};
            if (i % 5 == 0) begin
                k = {4{32'hC0DE_0000 + i}} ^ {96'h0, 32'hFFFF_FFFF * (i & 1)};
                drive(1, 1, k, p, "R5");
            end else begin
                drive(1, 0, {8{i[15:0] ^ 16'hDEAD}}, p, "R5");
            end
        end

        // R6: interleave bubbles with real blocks
        for (int i = 0; i < 10; i++) begin
            if (i % 2 == 0) drive(1, 0, '1, {8{16'h0F0F + i[15:0]}}, "R6");
            else            idle(1);
        end

        // R9: key load on an idle edge, then blocks without load
        drive(0, 1, 128'hfedcba98765432100123456789abcdef, '0, "R9");
        for (int i = 0; i < 3; i++) drive(1, 0, '0, {16{i[7:0] + 8'h31}}, "R9");

        // R4: load a new key with every block, back to back
        for (int i = 0; i < 6; i++)
            drive(1, 1, {16{8'h11 * i[7:0]}} ^ 128'h8000_0000_0000_0000_0000_0000_0000_0001,
                  {8{16'hA5C3 ^ i[15:0]}}, "R4");
        idle(14);

        // R8: reset with blocks in flight
        for (int i = 0; i < 5; i++) drive(1, 1, {4{32'h7777_0000 + i}}, {4{32'h2468_0000 + i}}, "R8");
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; key_load = 1'b0;
        exp_q.delete(); due_q.delete(); tag_q.delete();
        model_key = '0;
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 14; i++) begin
            @(posedge clk); #2;
            checks++;
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL R8 flushed block emerged: actual out_valid %b expected 0", out_valid);
            end
        end
        // R8: key register cleared, block without load uses the zero key
        drive(1, 0, {4{32'hFFFF_0000}}, 128'h0123456789abcdeffedcba9876543210, "R8");
        idle(14);

        checks++;
        if (due_q.size() != 0) begin
            errors++;
            $display("FAIL R2 outputs never seen: actual %0d pending expected 0", due_q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule